// File: doc/BRIEF.md
# Priority Message Bus Arbiter

This block is the central arbiter for a shared 32-bit synchronous message bus with several controller devices attached. Each device has its own request and grant pair. A device that needs to move a message raises its request and says which class of message it carries: a data message, which carries a frame between ports, or a command message, which carries control information between devices. A device may also tag its request as high priority. The high-priority tags together form the shared urgent-request line, and any tag on it preempts the pending normal requests.

After a grant, the arbiter watches the bus control lines. These are the message envelope, which stays active for the whole transfer, the initiator-ready qualifier, the end-of-frame marker and the target abort. From them the arbiter knows when the bus is owned and how many words have been accepted. It also knows when a message finished normally and when it was cut short. An overload input blocks data-class grants because no forwarding bandwidth is left, while command traffic still gets through. The message contents and the frame data path are outside this block.

Top module: `msg_bus_arb`

## Requirements
- R1: After reset, gnt is all zero, busy, msg_done, msg_abort and frame_end are 0, and words is 0. The round-robin pointer starts so that requester 0 wins the first grant.
- R2: A grant is issued only when no grant is outstanding, no message is owned and env is low, or in the cycle the owner releases env. gnt is one-hot (bit i grants requester i) and is visible one clock after the qualifying request is sampled.
- R3: Among eligible requesters at the same priority level, the grant goes to the first requester found by searching upward from the last granted index, wrapping from N-1 to 0.
- R4: If any eligible requester has its pri_hi bit set, only requesters with pri_hi set are considered.
- R5: While ovld is 1, requesters with is_data set are not eligible for a new grant. Requesters with is_data clear are still granted.
- R6: An outstanding grant to a data-class requester whose envelope has not yet started is withdrawn at the next clock edge that samples ovld at 1.
- R7: If env is not sampled high during the two cycles that gnt is high, the grant is withdrawn at the second edge and no ownership follows.
- R8: When env is sampled high while a grant is outstanding, gnt drops and busy rises at that edge.
- R9: words restarts at message start, counting that first word only if irdy is 1. It then increments once per owned cycle with env and irdy both 1. Cycles with irdy at 0 are wait states and leave it unchanged.
- R10: frame_end pulses for one cycle after an owned cycle with env, irdy and eof all 1. An eof sampled with irdy at 0 produces no pulse.
- R11: When the owner's env is sampled low, msg_done pulses for one cycle and busy falls. A new grant may be issued at that same edge.
- R12: When tabt is sampled high during ownership, msg_abort pulses for one cycle, busy falls at once, the word count is not advanced, and no grant is issued until env is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Per-requester bus request |
| pri_hi | input | N | Per-requester high-priority tag (the shared urgent line) |
| is_data | input | N | 1 = request is for a data message, 0 = command message |
| ovld | input | 1 | Forwarding bandwidth exhausted |
| env | input | 1 | Message envelope, high for the whole transfer |
| eof | input | 1 | End-of-frame marker with the status word |
| irdy | input | 1 | Initiator ready; 0 marks a wait state |
| tabt | input | 1 | Target abort |
| gnt | output | N | One-hot grant |
| busy | output | 1 | A message currently owns the bus |
| msg_done | output | 1 | One-cycle pulse on normal message end |
| msg_abort | output | 1 | One-cycle pulse on aborted message |
| frame_end | output | 1 | One-cycle pulse on an accepted end-of-frame word |
| words | output | CW | Words accepted in the current or last message |

## Verification
A wrong owner, pointer or class latch in this block shows up at gnt within one clock. It appears as the wrong one-hot bit on the next handover, or as a data grant that survives an overload. A stuck ownership state shows up at busy, and at the missing msg_done or msg_abort pulse, at the edge after the envelope falls or the abort arrives. A bad word count is seen on words one clock after the offending wait-state or end-of-frame cycle. The scenarios chain handovers, timeouts, overload and aborts back to back, so a state left over from one case corrupts the next grant.

// File: rtl/msg_bus_arb.sv
module msg_bus_arb #(
  parameter int N  = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  pri_hi,
  input  logic [N-1:0]  is_data,
  input  logic          ovld,
  input  logic          env,
  input  logic          eof,
  input  logic          irdy,
  input  logic          tabt,
  output logic [N-1:0]  gnt,
  output logic          busy,
  output logic          msg_done,
  output logic          msg_abort,
  output logic          frame_end,
  output logic [CW-1:0] words
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_OFFER, S_OWN} st_t;

  st_t           st;
  logic [IW-1:0] last, own;
  logic          tmr;

  logic [N-1:0]  elig, hi_set, pool, win_oh;
  logic [IW-1:0] win_idx;
  logic          any_win;

  assign elig    = req & ~(is_data & {N{ovld}});
  assign hi_set  = elig & pri_hi;
  assign pool    = (|hi_set) ? hi_set : elig;
  assign any_win = |pool;
  assign busy    = (st == S_OWN);

  always_comb begin
    logic found;
    found   = 1'b0;
    win_oh  = '0;
    win_idx = last;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(last) + i) % N;
      if (!found && pool[k]) begin
        found     = 1'b1;
        win_oh[k] = 1'b1;
        win_idx   = IW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      gnt       <= '0;
      last      <= IW'(N - 1);
      own       <= '0;
      tmr       <= 1'b0;
      msg_done  <= 1'b0;
      msg_abort <= 1'b0;
      frame_end <= 1'b0;
      words     <= '0;
    end else begin
      msg_done  <= 1'b0;
      msg_abort <= 1'b0;
      frame_end <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!env && any_win) begin
            st   <= S_OFFER;
            gnt  <= win_oh;
            own  <= win_idx;
            last <= win_idx;
            tmr  <= 1'b0;
          end
        end
        S_OFFER: begin
          if (ovld && is_data[own]) begin
            st  <= S_IDLE;
            gnt <= '0;
          end else if (env) begin
            st    <= S_OWN;
            gnt   <= '0;
            words <= irdy ? CW'(1) : '0;
          end else if (tmr) begin
            st  <= S_IDLE;
            gnt <= '0;
          end else begin
            tmr <= 1'b1;
          end
        end
        S_OWN: begin
          if (tabt) begin
            st        <= S_IDLE;
            msg_abort <= 1'b1;
          end else if (!env) begin
            msg_done <= 1'b1;
            if (any_win) begin
              st   <= S_OFFER;
              gnt  <= win_oh;
              own  <= win_idx;
              last <= win_idx;
              tmr  <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else if (irdy) begin
            words     <= words + CW'(1);
            frame_end <= eof;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msg_bus_arb_chk.sv
module msg_bus_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] is_data,
  input logic         ovld,
  input logic [N-1:0] gnt,
  input logic         busy,
  input logic         msg_done,
  input logic         msg_abort
);
  p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_gnt_busy_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && (gnt != '0)));

  p_ovld_blocks_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovld && gnt == '0) |=> ((gnt & $past(is_data)) == '0));

  p_grant_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gnt) != '0 && gnt != '0) |-> gnt == $past(gnt));

  p_abort_frees_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_abort |-> (!busy && gnt == '0));

  p_done_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> !busy);
endmodule

bind msg_bus_arb msg_bus_arb_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_data(is_data), .ovld(ovld),
  .gnt(gnt), .busy(busy), .msg_done(msg_done), .msg_abort(msg_abort)
);

// File: tb/sim_msg_bus_arb.sv
module sim_msg_bus_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] req = '0, pri_hi = '0, is_data = '0;
  logic ovld = 0, env = 0, eof = 0, irdy = 0, tabt = 0;
  logic [3:0] gnt;
  logic busy, msg_done, msg_abort, frame_end;
  logic [7:0] words;

  msg_bus_arb #(.N(4), .CW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .pri_hi(pri_hi), .is_data(is_data),
    .ovld(ovld), .env(env), .eof(eof), .irdy(irdy), .tabt(tabt),
    .gnt(gnt), .busy(busy), .msg_done(msg_done), .msg_abort(msg_abort),
    .frame_end(frame_end), .words(words));

  always #4 clk = ~clk;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic step(input [3:0] rq, hi, dt, input ov, en, ef, ir, ta,
                      input [3:0] eg, input eb, ed, ea, efe, input [7:0] ew,
                      input string tg);
    @(negedge clk);
    req = rq; pri_hi = hi; is_data = dt;
    ovld = ov; env = en; eof = ef; irdy = ir; tabt = ta;
    exp_q.push_back({eg, eb, ed, ea, efe, ew});
    tag_q.push_back(tg);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [15:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {gnt, busy, msg_done, msg_abort, frame_end, words};
        compared++;
        if (a !== e) begin
          mismatched++;
          $display("FAIL %s: got gnt=%b busy=%b done=%b abt=%b fend=%b words=%0d, expected gnt=%b busy=%b done=%b abt=%b fend=%b words=%0d",
                   t, a[15:12], a[11], a[10], a[9], a[8], a[7:0],
                   e[15:12], e[11], e[10], e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    //     req     hi      dat     ov en ef ir ta  gnt     b d a f words
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,0,0,0, 8'd0, "R1 reset state");
    step(4'b0001,4'b0000,4'b0000, 0,0,0,0,0, 4'b0001, 0,0,0,0, 8'd0, "R2 first grant");
    step(4'b0001,4'b0000,4'b0000, 0,1,0,1,0, 4'b0000, 1,0,0,0, 8'd1, "R8 envelope takes bus");
    step(4'b0000,4'b0000,4'b0000, 0,1,0,0,0, 4'b0000, 1,0,0,0, 8'd1, "R9 wait state");
    step(4'b0000,4'b0000,4'b0000, 0,1,0,1,0, 4'b0000, 1,0,0,0, 8'd2, "R9 word counted");
    step(4'b0000,4'b0000,4'b0000, 0,1,1,1,0, 4'b0000, 1,0,0,1, 8'd3, "R10 end of frame");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,1,0,0, 8'd3, "R11 normal end");
    step(4'b1111,4'b0000,4'b0000, 0,0,0,0,0, 4'b0010, 0,0,0,0, 8'd3, "R3 rotate to 1");
    step(4'b1111,4'b0000,4'b0000, 0,1,0,1,0, 4'b0000, 1,0,0,0, 8'd1, "R8 owner 1");
    step(4'b1111,4'b0000,4'b0000, 0,0,0,0,0, 4'b0100, 0,1,0,0, 8'd1, "R11 handover to 2");
    step(4'b1111,4'b0000,4'b0000, 0,1,0,0,0, 4'b0000, 1,0,0,0, 8'd0, "R9 start in wait");
    step(4'b1111,4'b0001,4'b0000, 0,0,0,0,0, 4'b0001, 0,1,0,0, 8'd0, "R4 high priority wins");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0001, 0,0,0,0, 8'd0, "R7 grant held");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,0,0,0, 8'd0, "R7 grant timeout");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,0,0,0, 8'd0, "R7 no regrant");
    step(4'b0110,4'b0000,4'b0010, 1,0,0,0,0, 4'b0100, 0,0,0,0, 8'd0, "R5 command passes overload");
    step(4'b0000,4'b0000,4'b0000, 1,1,0,1,0, 4'b0000, 1,0,0,0, 8'd1, "R5 command owns");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,1,0,0, 8'd1, "R11 end");
    step(4'b0010,4'b0000,4'b0010, 0,0,0,0,0, 4'b0010, 0,0,0,0, 8'd1, "R6 data grant");
    step(4'b0010,4'b0000,4'b0010, 1,0,0,0,0, 4'b0000, 0,0,0,0, 8'd1, "R6 overload withdraws");
    step(4'b0010,4'b0000,4'b0010, 1,0,0,0,0, 4'b0000, 0,0,0,0, 8'd1, "R5 data blocked");
    step(4'b1000,4'b0000,4'b0000, 0,0,0,0,0, 4'b1000, 0,0,0,0, 8'd1, "R2 grant 3");
    step(4'b1000,4'b0000,4'b0000, 0,1,0,1,0, 4'b0000, 1,0,0,0, 8'd1, "R8 owner 3");
    step(4'b1000,4'b0000,4'b0000, 0,1,0,1,1, 4'b0000, 0,0,1,0, 8'd1, "R12 abort");
    step(4'b1000,4'b0000,4'b0000, 0,1,0,0,0, 4'b0000, 0,0,0,0, 8'd1, "R12 no grant under envelope");
    step(4'b1000,4'b0000,4'b0000, 0,0,0,0,0, 4'b1000, 0,0,0,0, 8'd1, "R2 grant after release");
    step(4'b0000,4'b0000,4'b0000, 0,1,1,0,0, 4'b0000, 1,0,0,0, 8'd0, "R10 start with eof in wait");
    step(4'b0000,4'b0000,4'b0000, 0,1,1,0,0, 4'b0000, 1,0,0,0, 8'd0, "R10 eof ignored in wait");
    step(4'b0000,4'b0000,4'b0000, 0,0,0,0,0, 4'b0000, 0,1,0,0, 8'd0, "R11 end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule